// File: doc/BRIEF.md
# Four-Lane PRBS Loopback Test Sequencer

This block runs a loopback test over four serial lanes and shows its progress on sixteen status LEDs. An operator walks it through three steps, each started by its own debounced button pulse: turn on comma detection so the receivers find word boundaries, then turn on lane bonding, then start pattern transmission. Once started, the block drives a PRBS-7 word on every lane on every clock. The bonded receive words come back through the external loopback and are compared, lane by lane, against a local receive-side generator. That generator seeds itself from the first received word, so it locks to whatever delay the loop adds.

A deliberate fault can be injected by pressing the bonding and start buttons in the same cycle while the test is running. This flips a single transmit bit, which must then show up as an error on the receive side. A broken loop also raises the error flag: a lane losing alignment, bonding dropping, or data that does not match. The error flag holds until the global reset.

States: ST_IDLE, ST_ALIGNING (comma detect enabled, waiting for every lane to align), ST_ALIGNED, ST_BONDING (bonding enabled, waiting for bond status), ST_BONDED, ST_SEEDING (transmitting, waiting for the first received word), ST_CHECKING and ST_COMPLETE. The transitions are:
- idle to aligning, on an align press while the PLL lock input is high;
- aligning to aligned, when all lanes report alignment;
- aligned to bonding, on a bond press without a start press;
- bonding to bonded, when bond status is high;
- bonded to seeding, on a start press without a bond press;
- seeding to checking, on the first valid receive word;
- checking to complete, on the compared word that brings the count to DONE_COUNT.

Every state returns to idle on reset.

Top module: `lbt_ctrl`

## Requirements
- R1: During and after a synchronous reset, led[3:0] reads 0 (apart from led[0], which follows the lock input), led[15:4] reads 12'h001, and align_en, bond_en and tx_valid are 0.
- R2: Buttons are accepted only in order. An align press is taken only in idle with pll_locked high, and align_en stays high from the next cycle on. Aligning ends once all rx_aligned bits are 1. A bond press is taken only in the aligned state, and bond_en stays high from the next cycle on. A start press is taken only in the bonded state. A press in any other state leaves align_en, bond_en and tx_valid unchanged.
- R3: From the cycle after an accepted start, tx_valid is 1 and every lane outputs a new 16-bit PRBS-7 word each cycle. Lane i occupies tx_data[16i+15:16i] and its generator starts from state 7'd127 minus i. One LFSR step shifts the state left and puts bit6 XOR bit5 into bit 0. The word's MSB is the first new bit produced and its LSB the sixteenth.
- R4: The first valid receive word after start seeds each lane's reference from that word's bits [6:0]. Each later valid word is compared on all four lanes against the next reference word, and any mismatch sets the error flag (led[3]) one cycle later.
- R5: led[1] (pattern sync) rises in the cycle after the seeding word and stays high until reset.
- R6: led[2] (test complete) rises in the cycle after the DONE_COUNT-th compared word.
- R7: While checking or complete, a rx_aligned bit at 0 or rx_bonded at 0 sets the error flag the next cycle. Once set, the error flag stays set until reset.
- R8: A bond and start press in the same cycle, while transmitting, inverts bit 0 of lane 0 in the next transmitted word only. The same double press in the bonded state is ignored and does not start transmission.
- R9: led[0] equals pll_locked delayed by one cycle.
- R10: led[15:4] is a one-hot walking pattern that moves one place toward the MSB, wrapping, every 2^HB_SHIFT cycles after reset.
- R11: A reset in the middle of a run clears pattern sync, complete, error, align_en, bond_en and tx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_align | input | 1 | One-cycle pulse: enable comma detection |
| btn_bond | input | 1 | One-cycle pulse: enable lane bonding |
| btn_start | input | 1 | One-cycle pulse: start PRBS transmission |
| pll_locked | input | 1 | All PLLs locked |
| rx_aligned | input | 4 | Per-lane word alignment achieved |
| rx_bonded | input | 1 | Lanes bonded (deskewed) |
| rx_valid | input | 1 | Bonded receive word valid |
| rx_data | input | 64 | Bonded receive words, lane i at [16i+15:16i] |
| align_en | output | 1 | Comma detection enable |
| bond_en | output | 1 | Lane bonding enable |
| tx_valid | output | 1 | Transmit words valid |
| tx_data | output | 64 | Transmit PRBS words, lane i at [16i+15:16i] |
| led | output | 16 | Status: 0 lock, 1 sync, 2 complete, 3 error, 15:4 heartbeat |

## Verification
Every result of this block is registered once. An accepted button shows on align_en, bond_en or tx_valid one cycle after the edge that samples it, and the first transmit word appears in that same cycle. A receive word that fails comparison or a lost lane status shows on led[3] one cycle after the edge that samples it. led[0] lags pll_locked by one cycle, and the heartbeat moves on the edge that completes each 2^HB_SHIFT-cycle period. The bench keeps a behavioural model that it updates on the same rising edge as the design and compares against every output at the following falling edge. Inputs change two nanoseconds after a rising edge, so each stimulus is seen at exactly one known edge.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGNING,
        ST_ALIGNED,
        ST_BONDING,
        ST_BONDED,
        ST_SEEDING,
        ST_CHECKING,
        ST_COMPLETE
    } lbt_state_e;

    localparam int PRBS_ORDER = 7;

    // One step of x^7 + x^6 + 1: new bit from taps 7 and 6 enters at bit 0
    function automatic logic [PRBS_ORDER-1:0] prbs7_step(input logic [PRBS_ORDER-1:0] s);
        return {s[PRBS_ORDER-2:0], s[6] ^ s[5]};
    endfunction

endpackage

// File: rtl/lbt_prbs_gen.sv
module lbt_prbs_gen
    import lbt_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter logic [PRBS_ORDER-1:0] SEED = 7'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              flip,
    output logic [WORD_W-1:0] word_q
);

    logic [PRBS_ORDER-1:0] state_q;
    logic [PRBS_ORDER-1:0] walk;
    logic [WORD_W-1:0]     next_word;

    // Unroll WORD_W serial steps; first produced bit lands in the MSB
    always_comb begin
        walk = state_q;
        for (int i = 0; i < WORD_W; i++) begin
            walk = prbs7_step(walk);
            next_word[WORD_W-1-i] = walk[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
            word_q  <= '0;
        end else if (step) begin
            state_q <= walk;
            word_q  <= next_word ^ {{(WORD_W-1){1'b0}}, flip};
        end
    end

endmodule

// File: rtl/lbt_prbs_chk.sv
module lbt_prbs_chk
    import lbt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              check,
    input  logic [WORD_W-1:0] rx_word,
    output logic              mismatch
);

    logic [PRBS_ORDER-1:0] ref_q;
    logic [PRBS_ORDER-1:0] walk;
    logic [WORD_W-1:0]     ref_word;

    always_comb begin
        walk = ref_q;
        for (int i = 0; i < WORD_W; i++) begin
            walk = prbs7_step(walk);
            ref_word[WORD_W-1-i] = walk[0];
        end
    end

    assign mismatch = check && (rx_word != ref_word);

    // The reference advances on its own sequence, so a single bad word
    // gives a single mismatch instead of a burst
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else if (load) begin
            ref_q <= rx_word[PRBS_ORDER-1:0];
        end else if (check) begin
            ref_q <= walk;
        end
    end

endmodule

// File: rtl/lbt_heartbeat.sv
module lbt_heartbeat #(
    parameter int HB_W     = 12,
    parameter int HB_SHIFT = 22
) (
    input  logic            clk,
    input  logic            rst,
    output logic [HB_W-1:0] pattern
);

    logic [HB_SHIFT-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= '0;
            pattern <= {{(HB_W-1){1'b0}}, 1'b1};
        end else begin
            tick_q <= tick_q + 1'b1;
            if (&tick_q) begin
                pattern <= {pattern[HB_W-2:0], pattern[HB_W-1]};
            end
        end
    end

endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
    import lbt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int WORD_W     = 16,
    parameter int DONE_COUNT = 65536,
    parameter int HB_SHIFT   = 22,
    parameter int HB_W       = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    btn_align,
    input  logic                    btn_bond,
    input  logic                    btn_start,
    input  logic                    pll_locked,
    input  logic [LANES-1:0]        rx_aligned,
    input  logic                    rx_bonded,
    input  logic                    rx_valid,
    input  logic [LANES*WORD_W-1:0] rx_data,
    output logic                    align_en,
    output logic                    bond_en,
    output logic                    tx_valid,
    output logic [LANES*WORD_W-1:0] tx_data,
    output logic [HB_W+3:0]         led
);

    localparam int CNT_W = $clog2(DONE_COUNT + 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DONE_COUNT - 1);

    lbt_state_e state_q, state_d;

    logic             pll_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tx_valid_q;
    logic [HB_W-1:0]  hb_pattern;
    logic [LANES-1:0] lane_mism;

    logic running, checking, start_ok, tx_go, inject;
    logic seed_load, cmp_en, status_lost;
    logic sync_led, done_led;

    // ---------------- state decode helpers ----------------
    assign running  = (state_q == ST_SEEDING) || (state_q == ST_CHECKING) ||
                      (state_q == ST_COMPLETE);
    assign checking = (state_q == ST_CHECKING) || (state_q == ST_COMPLETE);
    assign start_ok = (state_q == ST_BONDED) && btn_start && !btn_bond;
    assign inject   = running && btn_bond && btn_start;
    assign tx_go    = running || start_ok;

    assign seed_load   = (state_q == ST_SEEDING) && rx_valid;
    assign cmp_en      = checking && rx_valid;
    assign status_lost = checking && (!(&rx_aligned) || !rx_bonded);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (btn_align && pll_locked)             state_d = ST_ALIGNING;
            ST_ALIGNING: if (&rx_aligned)                         state_d = ST_ALIGNED;
            ST_ALIGNED:  if (btn_bond && !btn_start)              state_d = ST_BONDING;
            ST_BONDING:  if (rx_bonded)                           state_d = ST_BONDED;
            ST_BONDED:   if (start_ok)                            state_d = ST_SEEDING;
            ST_SEEDING:  if (rx_valid)                            state_d = ST_CHECKING;
            ST_CHECKING: if (rx_valid && (cnt_q == LAST_WORD))    state_d = ST_COMPLETE;
            ST_COMPLETE:                                          state_d = ST_COMPLETE;
            default:                                              state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs from state ----------------
    always_comb begin
        align_en = 1'b0;
        bond_en  = 1'b0;
        sync_led = 1'b0;
        done_led = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ALIGNING, ST_ALIGNED: align_en = 1'b1;
            ST_BONDING, ST_BONDED, ST_SEEDING: begin
                align_en = 1'b1;
                bond_en  = 1'b1;
            end
            ST_CHECKING: begin
                align_en = 1'b1;
                bond_en  = 1'b1;
                sync_led = 1'b1;
            end
            ST_COMPLETE: begin
                align_en = 1'b1;
                bond_en  = 1'b1;
                sync_led = 1'b1;
                done_led = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_valid = tx_valid_q;
    assign led      = {hb_pattern, err_q, done_led, sync_led, pll_q};

    // ---------------- status registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pll_q      <= 1'b0;
            err_q      <= 1'b0;
            cnt_q      <= '0;
            tx_valid_q <= 1'b0;
        end else begin
            pll_q      <= pll_locked;
            tx_valid_q <= tx_go;
            if (status_lost || (|lane_mism)) begin
                err_q <= 1'b1;
            end
            if ((state_q == ST_CHECKING) && rx_valid) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // ---------------- per-lane generators and checkers ----------------
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lbt_prbs_gen #(
            .WORD_W (WORD_W),
            .SEED   (PRBS_ORDER'(127 - l))
        ) u_gen (
            .clk    (clk),
            .rst    (rst),
            .step   (tx_go),
            .flip   (inject && (l == 0)),
            .word_q (tx_data[l*WORD_W +: WORD_W])
        );

        lbt_prbs_chk #(
            .WORD_W (WORD_W)
        ) u_chk (
            .clk      (clk),
            .rst      (rst),
            .load     (seed_load),
            .check    (cmp_en),
            .rx_word  (rx_data[l*WORD_W +: WORD_W]),
            .mismatch (lane_mism[l])
        );
    end

    lbt_heartbeat #(
        .HB_W     (HB_W),
        .HB_SHIFT (HB_SHIFT)
    ) u_hb (
        .clk     (clk),
        .rst     (rst),
        .pattern (hb_pattern)
    );

endmodule

// File: rtl/lbt_ctrl_sva.sv
module lbt_ctrl_sva #(
    parameter int HB_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            pll_locked,
    input logic            rx_valid,
    input logic            align_en,
    input logic            bond_en,
    input logic            tx_valid,
    input logic [HB_W+3:0] led
);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        led[3] |=> led[3]);                                        // R7

    AST_SYNC_AFTER_BOND: assert property (@(posedge clk) disable iff (rst)
        led[1] |-> (align_en && bond_en));                         // R5

    AST_SYNC_FROM_RX_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(led[1]) |-> $past(rx_valid));                        // R5

    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_valid);                                    // R3

    AST_DONE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
        led[2] |-> led[1]);                                        // R6

    AST_HB_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(led[HB_W+3:4]) == 1);                           // R10

    AST_LOCK_LED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (led[0] == $past(pll_locked)));            // R9

    AST_BOND_AFTER_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(bond_en) |-> $past(align_en));                       // R2

endmodule

bind lbt_ctrl lbt_ctrl_sva #(.HB_W(HB_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .pll_locked (pll_locked),
    .rx_valid   (rx_valid),
    .align_en   (align_en),
    .bond_en    (bond_en),
    .tx_valid   (tx_valid),
    .led        (led)
);

// File: tb/lbt_ctrl_tb.sv
`timescale 1ns/1ps
module lbt_ctrl_tb;

    localparam int LANES = 4;
    localparam int WW    = 16;
    localparam int DONE  = 40;
    localparam int HBS   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_align = 1'b0, btn_bond = 1'b0, btn_start = 1'b0;
    logic        pll_locked = 1'b0;
    logic [3:0]  rx_aligned = 4'h0;
    logic        rx_bonded = 1'b0;
    logic        rx_valid;
    logic [63:0] rx_data;
    logic        align_en, bond_en, tx_valid;
    logic [63:0] tx_data;
    logic [15:0] led;

    // loopback environment: two register stages plus optional corruption
    logic [63:0] p1, p2;
    logic        v1, v2;
    logic [63:0] cmask = 64'h0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lbt_ctrl #(
        .LANES(LANES), .WORD_W(WW), .DONE_COUNT(DONE), .HB_SHIFT(HBS), .HB_W(12)
    ) u_dut (
        .clk(clk), .rst(rst), .btn_align(btn_align), .btn_bond(btn_bond),
        .btn_start(btn_start), .pll_locked(pll_locked), .rx_aligned(rx_aligned),
        .rx_bonded(rx_bonded), .rx_valid(rx_valid), .rx_data(rx_data),
        .align_en(align_en), .bond_en(bond_en), .tx_valid(tx_valid),
        .tx_data(tx_data), .led(led)
    );

    always @(posedge clk) begin
        if (rst) begin
            p1 <= '0; p2 <= '0; v1 <= 1'b0; v2 <= 1'b0;
        end else begin
            p1 <= tx_data; p2 <= p1; v1 <= tx_valid; v2 <= v1;
        end
    end
    assign rx_data  = p2 ^ cmask;
    assign rx_valid = v2;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic logic [15:0] serial_prbs(input int s0, output int s_out);
        int s = s0;
        logic [15:0] w;
        for (int k = 0; k < 16; k++) begin
            int b;
            b = ((s >> 6) ^ (s >> 5)) & 1;
            s = ((s << 1) | b) & 127;
            w[15-k] = b[0];
        end
        s_out = s;
        return w;
    endfunction

    int          m_phase;   // 0 idle .. 7 complete
    int          m_cnt, m_hb;
    bit          m_err, m_pll, m_txv, m_inj;
    logic [63:0] m_txd;
    int          m_tx[4];
    int          m_ref[4];

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_hb = 0; m_err = 0; m_pll = 0;
            m_txv = 0; m_inj = 0; m_txd = '0;
            for (int l = 0; l < 4; l++) begin m_tx[l] = 127 - l; m_ref[l] = 0; end
        end else begin
            bit run, cmp, go, inj, sok;
            run = (m_phase >= 5);
            cmp = (m_phase >= 6);
            sok = (m_phase == 4) && btn_start && !btn_bond;
            inj = run && btn_bond && btn_start;
            go  = run || sok;
            if (cmp && ((rx_aligned != 4'hF) || !rx_bonded)) m_err = 1;
            if (rx_valid && m_phase == 5) begin
                for (int l = 0; l < 4; l++) m_ref[l] = int'(rx_data[l*16 +: 7]);
            end else if (rx_valid && cmp) begin
                for (int l = 0; l < 4; l++) begin
                    int ns;
                    logic [15:0] w;
                    w = serial_prbs(m_ref[l], ns);
                    m_ref[l] = ns;
                    if (rx_data[l*16 +: 16] != w) m_err = 1;
                end
            end
            if (go) begin
                for (int l = 0; l < 4; l++) begin
                    int ns;
                    logic [15:0] w;
                    w = serial_prbs(m_tx[l], ns);
                    m_tx[l] = ns;
                    if (inj && l == 0) w[0] = ~w[0];
                    m_txd[l*16 +: 16] = w;
                end
            end
            m_txv = go;
            m_inj = inj;
            case (m_phase)
                0: if (btn_align && pll_locked) m_phase = 1;
                1: if (rx_aligned == 4'hF) m_phase = 2;
                2: if (btn_bond && !btn_start) m_phase = 3;
                3: if (rx_bonded) m_phase = 4;
                4: if (sok) m_phase = 5;
                5: if (rx_valid) m_phase = 6;
                6: if (rx_valid) begin m_cnt++; if (m_cnt == DONE) m_phase = 7; end
                default: ;
            endcase
            m_pll = pll_locked;
            m_hb++;
        end
    end

    // compare every output at each falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [11:0] hb_exp;
            hb_exp = 12'(1) << ((m_hb >> HBS) % 12);
            chk(led[0] == m_pll, "R9 lock led", 64'(led[0]), 64'(m_pll));
            chk(led[1] == (m_phase >= 6), "R5 sync led", 64'(led[1]), 64'(m_phase >= 6));
            chk(led[2] == (m_phase == 7), "R6 complete led", 64'(led[2]), 64'(m_phase == 7));
            chk(led[3] == m_err, "R7 error led", 64'(led[3]), 64'(m_err));
            chk(led[15:4] == hb_exp, "R10 heartbeat", 64'(led[15:4]), 64'(hb_exp));
            chk(align_en == (m_phase >= 1), "R2 align_en", 64'(align_en), 64'(m_phase >= 1));
            chk(bond_en == (m_phase >= 3), "R2 bond_en", 64'(bond_en), 64'(m_phase >= 3));
            chk(tx_valid == m_txv, "R3 tx_valid", 64'(tx_valid), 64'(m_txv));
            chk(tx_data == m_txd, m_inj ? "R8 injected word" : "R3 tx_data", tx_data, m_txd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic press(input bit a, input bit b, input bit s);
        @(posedge clk); #2;
        btn_align = a; btn_bond = b; btn_start = s;
        @(posedge clk); #2;
        btn_align = 0; btn_bond = 0; btn_start = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst = 1;
        @(posedge clk); #2; rst = 0;
    endtask

    task automatic bring_up();
        press(1, 0, 0); idle(3);
        press(0, 1, 0); idle(3);
        press(0, 0, 1); idle(12);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        idle(5);
        rst = 0;
        @(negedge clk);
        chk(led == 16'h0010, "R1 reset leds", 64'(led), 64'h0010);
        chk({align_en, bond_en, tx_valid} == 3'b000, "R1 reset enables",
            64'({align_en, bond_en, tx_valid}), 64'h0);

        press(1, 0, 0); @(negedge clk);
        chk(align_en == 0, "R2 align ignored without lock", 64'(align_en), 64'h0);
        pll_locked = 1;
        press(0, 1, 0); @(negedge clk);
        chk(bond_en == 0, "R2 bond ignored before align", 64'(bond_en), 64'h0);
        press(1, 0, 0); @(negedge clk);
        chk(align_en == 1, "R2 align accepted", 64'(align_en), 64'h1);
        rx_aligned = 4'hF; idle(3);
        press(0, 0, 1); @(negedge clk);
        chk(tx_valid == 0, "R2 start ignored before bond", 64'(tx_valid), 64'h0);
        press(0, 1, 0); rx_bonded = 1; idle(3);
        press(0, 1, 1); @(negedge clk);
        chk(tx_valid == 0, "R8 double press ignored when bonded", 64'(tx_valid), 64'h0);
        press(0, 0, 1); @(negedge clk);
        chk(tx_valid == 1, "R3 transmission started", 64'(tx_valid), 64'h1);

        idle(DONE + 20); @(negedge clk);
        chk(led[3:1] == 3'b011, "R6 clean run complete", 64'(led[3:1]), 64'h3);

        press(0, 1, 1); idle(6); @(negedge clk);
        chk(led[3] == 1, "R8 injected error seen", 64'(led[3]), 64'h1);
        idle(8); @(negedge clk);
        chk(led[3] == 1, "R7 error sticky", 64'(led[3]), 64'h1);

        do_reset(); @(negedge clk);
        chk({led[3:1], align_en, bond_en, tx_valid} == 6'b0, "R11 mid-run reset",
            64'({led[3:1], align_en, bond_en, tx_valid}), 64'h0);

        bring_up();
        rx_aligned = 4'hB; idle(2); @(negedge clk);
        chk(led[3] == 1, "R7 lane loss", 64'(led[3]), 64'h1);
        rx_aligned = 4'hF; idle(4); @(negedge clk);
        chk(led[3] == 1, "R7 still set after recovery", 64'(led[3]), 64'h1);

        do_reset(); bring_up();
        @(negedge clk);
        chk(led[3] == 0, "R4 clean before corruption", 64'(led[3]), 64'h0);
        @(posedge clk); #2; cmask = 64'h0100_0000_0000_0000;
        @(posedge clk); #2; cmask = 64'h0;
        idle(2); @(negedge clk);
        chk(led[3] == 1, "R4 lane3 mismatch", 64'(led[3]), 64'h1);

        pll_locked = 0; idle(1); @(negedge clk);
        chk(led[0] == 0, "R9 lock lost", 64'(led[0]), 64'h0);
        idle(40);
        finished = 1;
        report();
    end

endmodule